// File: doc/BRIEF.md
# Error Report Register with Serial Readout

This block keeps the latest error report produced by a frame checker: the index of the frame that failed, the offset of the faulty bit inside that frame, and a two-bit error class. A host reads the report through a serial path that behaves like a boundary-scan data register. A capture strobe copies the report into a shift register. Each shift strobe moves one bit out and one bit in. An update strobe that follows a full shift-out marks the report as consumed.

Reports can arrive faster than the host reads them. With the hold setting at zero, a new report replaces an unread one at once and sets a sticky overrun flag. With a non-zero hold setting N (at most seven), the new report waits in a one-entry pending slot. It moves into the report register when the host finishes reading the current report, or on the Nth frame-done pulse, whichever comes first. If it is promoted on the frame-done pulse, the overrun flag is set. The overrun flag travels with the report as its most significant bit.

Top module: `err_report_reg`

## Requirements
- R1: After reset, the report is not valid, the overrun and pending flags are low, and `sdo` is 0.
- R2: A report that arrives while no valid report is held is loaded. `rpt_valid` goes high in the next cycle with `rpt_overrun` low.
- R3: The readout word is, from bit 0 upward: the error class (2 bits, codes 0 none, 1 single, 2 double-adjacent, 3 multi), the bit offset (OFFS_W bits), the frame index (FRAME_W bits), and the overrun flag. After a capture strobe, `sdo` shows bit 0 in the next cycle. Each shift strobe advances `sdo` by one bit and shifts `sdi` in at the top bit.
- R4: An update strobe clears `rpt_valid` and `rpt_overrun` only if a capture was followed by at least one full word of shift strobes. An update strobe after fewer shifts has no effect.
- R5: With the hold setting at 0, a report that arrives while a valid report is held replaces it at once and sets `rpt_overrun`.
- R6: With the hold setting N > 0, a report that arrives while a valid report is held goes to the pending slot (`rpt_pending` high). It replaces the current report, and sets the overrun flag, on the Nth frame-done pulse after it arrived.
- R7: When the current report is read out (R4) while a report is pending, the pending report becomes current in the same cycle, with the overrun flag clear and `rpt_pending` low.
- R8: A report that arrives while one is already pending replaces the pending one, restarts the frame count, and sets the overrun flag.
- R9: When a new report enters the report register between a capture and its update, that update does not consume the new report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| new_valid | input | 1 | One-cycle strobe: a new error report is present |
| new_kind | input | 2 | Error class of the new report |
| new_offs | input | OFFS_W | Bit offset of the new report |
| new_frame | input | FRAME_W | Frame index of the new report |
| frame_done | input | 1 | Pulse at the end of each frame check |
| hold_frames | input | EXT_W | Extra frame periods a new report waits before overwriting |
| cap | input | 1 | Capture strobe |
| shift | input | 1 | Shift strobe |
| upd | input | 1 | Update strobe |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (bit 0 of the shift register) |
| rpt_valid | output | 1 | An unread report is held |
| rpt_overrun | output | 1 | An unread report was overwritten |
| rpt_pending | output | 1 | A report waits in the pending slot |

## Verification
Every flag is registered. A report strobe, a frame-done pulse or an update strobe therefore shows its effect on `rpt_valid`, `rpt_overrun` and `rpt_pending` exactly one cycle later. The bench drives strobes on the falling edge and reads the flags on the next falling edge, half a cycle after the register has updated. `sdo` follows the shift register directly: the bench reads each readout bit on the falling edge after the capture or shift that exposed it. It then assembles the bits into a word, and a monitor compares that word with the word the driver queued from the requirement layout.

// File: rtl/erpt_pkg.sv
package erpt_pkg;
    parameter int FRAME_W = 6;
    parameter int OFFS_W  = 8;
    parameter int EXT_W   = 3;

    typedef enum logic [1:0] {
        ERR_NONE       = 2'd0,
        ERR_SINGLE     = 2'd1,
        ERR_DOUBLE_ADJ = 2'd2,
        ERR_MULTI      = 2'd3
    } err_kind_e;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [OFFS_W-1:0]  offs;
        err_kind_e          kind;
    } err_loc_t;

    typedef struct packed {
        logic     ovr;
        err_loc_t loc;
    } err_word_t;

    localparam int WORD_W = $bits(err_word_t);
    localparam int SCNT_W = $clog2(WORD_W + 1);
endpackage

// File: rtl/err_report_shift.sv
module err_report_shift
    import erpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic              shift,
    input  logic              upd,
    input  logic              sdi,
    input  logic              disarm,
    input  logic [WORD_W-1:0] par_in,
    output logic              sdo,
    output logic              read_done
);
    logic [WORD_W-1:0] sreg;
    logic [SCNT_W-1:0] cnt;
    logic              armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg  <= '0;
            cnt   <= '0;
            armed <= 1'b0;
        end else begin
            if (cap) begin
                sreg  <= par_in;
                cnt   <= '0;
                armed <= 1'b1;
            end else if (shift) begin
                sreg <= {sdi, sreg[WORD_W-1:1]};
                if (cnt != SCNT_W'(WORD_W)) cnt <= cnt + 1'b1;
            end
            if (upd || disarm) armed <= 1'b0;
        end
    end

    assign sdo       = sreg[0];
    assign read_done = upd && armed && (cnt == SCNT_W'(WORD_W));

    // R3: capture exposes bit 0 of the parallel word on the next cycle
    a_r3_capture_lsb: assert property (@(posedge clk) disable iff (rst)
        cap |=> sdo == $past(par_in[0]));
    // R3: each shift advances the serial output by one position
    a_r3_shift_step: assert property (@(posedge clk) disable iff (rst)
        (shift && !cap) |=> sdo == $past(sreg[1]));
endmodule

// File: rtl/err_report_slot.sv
module err_report_slot
    import erpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             new_valid,
    input  err_loc_t         new_loc,
    input  logic             frame_done,
    input  logic [EXT_W-1:0] hold_frames,
    input  logic             read_done,
    output err_word_t        cur_word,
    output logic             valid,
    output logic             pend_v,
    output logic             load_now
);
    err_loc_t         cur, pend, n_cur, n_pend;
    logic             ovr, n_ovr, n_valid, n_pend_v;
    logic [EXT_W-1:0] cnt, n_cnt;
    logic             eff_valid, hit;

    assign eff_valid = valid && !read_done;
    assign hit = frame_done &&
                 (((EXT_W+1)'(cnt) + 1'b1) == (EXT_W+1)'(hold_frames));

    always_comb begin
        n_cur    = cur;
        n_pend   = pend;
        n_ovr    = ovr;
        n_valid  = valid;
        n_pend_v = pend_v;
        n_cnt    = cnt;
        load_now = 1'b0;
        if (read_done) begin
            n_valid = 1'b0;
            n_ovr   = 1'b0;
        end
        if (new_valid) begin
            if (!eff_valid) begin
                load_now = 1'b1;
                n_valid  = 1'b1;
                if (pend_v) begin
                    n_cur  = pend;
                    n_pend = new_loc;
                    n_cnt  = '0;
                end else begin
                    n_cur = new_loc;
                end
            end else if (hold_frames == '0) begin
                load_now = 1'b1;
                n_cur    = new_loc;
                n_ovr    = 1'b1;
                n_pend_v = 1'b0;
            end else begin
                n_pend   = new_loc;
                n_pend_v = 1'b1;
                n_cnt    = '0;
                if (pend_v) n_ovr = 1'b1;
            end
        end else if (pend_v) begin
            if (!eff_valid) begin
                load_now = 1'b1;
                n_cur    = pend;
                n_valid  = 1'b1;
                n_pend_v = 1'b0;
            end else if (hit) begin
                load_now = 1'b1;
                n_cur    = pend;
                n_ovr    = 1'b1;
                n_pend_v = 1'b0;
            end else if (frame_done) begin
                n_cnt = cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur    <= '0;
            pend   <= '0;
            ovr    <= 1'b0;
            valid  <= 1'b0;
            pend_v <= 1'b0;
            cnt    <= '0;
        end else begin
            cur    <= n_cur;
            pend   <= n_pend;
            ovr    <= n_ovr;
            valid  <= n_valid;
            pend_v <= n_pend_v;
            cnt    <= n_cnt;
        end
    end

    assign cur_word = '{ovr: ovr, loc: cur};

    // R5: overrun is only reported against a held report
    a_r5_ovr_needs_valid: assert property (@(posedge clk) disable iff (rst)
        ovr |-> valid);
    // R6: a pending report only exists behind a valid one
    a_r6_pend_needs_valid: assert property (@(posedge clk) disable iff (rst)
        pend_v |-> valid);
    // R2: a report loaded into an empty register carries no overrun
    a_r2_fresh_no_ovr: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> !ovr);
    // R6: without a frame pulse, arrival or readout the pending slot stays
    a_r6_pend_kept: assert property (@(posedge clk) disable iff (rst)
        (pend_v && !frame_done && !new_valid && !read_done) |=> pend_v);
endmodule

// File: rtl/err_report_reg.sv
module err_report_reg
    import erpt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               new_valid,
    input  logic [1:0]         new_kind,
    input  logic [OFFS_W-1:0]  new_offs,
    input  logic [FRAME_W-1:0] new_frame,
    input  logic               frame_done,
    input  logic [EXT_W-1:0]   hold_frames,
    input  logic               cap,
    input  logic               shift,
    input  logic               upd,
    input  logic               sdi,
    output logic               sdo,
    output logic               rpt_valid,
    output logic               rpt_overrun,
    output logic               rpt_pending
);
    err_loc_t  new_loc;
    err_word_t cur_word;
    logic      read_done, load_now;

    assign new_loc = '{frame: new_frame, offs: new_offs, kind: err_kind_e'(new_kind)};

    err_report_slot u_slot (
        .clk         (clk),
        .rst         (rst),
        .new_valid   (new_valid),
        .new_loc     (new_loc),
        .frame_done  (frame_done),
        .hold_frames (hold_frames),
        .read_done   (read_done),
        .cur_word    (cur_word),
        .valid       (rpt_valid),
        .pend_v      (rpt_pending),
        .load_now    (load_now)
    );

    err_report_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .cap       (cap),
        .shift     (shift),
        .upd       (upd),
        .sdi       (sdi),
        .disarm    (load_now),
        .par_in    (cur_word),
        .sdo       (sdo),
        .read_done (read_done)
    );

    assign rpt_overrun = cur_word.ovr;

    // R4: a completed readout with nothing waiting leaves the register empty
    a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
        (read_done && !rpt_pending && !new_valid) |=> !rpt_valid && !rpt_overrun);
endmodule

// File: tb/sim_err_report_reg.sv
module sim_err_report_reg;
    import erpt_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic new_valid = 1'b0, frame_done = 1'b0, cap = 1'b0, shift = 1'b0, upd = 1'b0, sdi = 1'b0;
    logic [1:0]         new_kind = '0;
    logic [OFFS_W-1:0]  new_offs = '0;
    logic [FRAME_W-1:0] new_frame = '0;
    logic [EXT_W-1:0]   hold_frames = '0;
    logic sdo, rpt_valid, rpt_overrun, rpt_pending;

    int n_tests = 0, n_fail = 0;
    logic [WORD_W-1:0] exp_q[$];
    logic [WORD_W-1:0] got_word;
    event word_done;
    bit finished = 0;

    always #2 clk = ~clk;

    err_report_reg u0 (.*);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [WORD_W-1:0] mk(logic o, logic [1:0] k, logic [OFFS_W-1:0] b, logic [FRAME_W-1:0] f);
        return {o, f, b, k};
    endfunction

    task automatic push(logic [1:0] k, logic [OFFS_W-1:0] b, logic [FRAME_W-1:0] f);
        new_kind = k; new_offs = b; new_frame = f; new_valid = 1'b1;
        @(negedge clk);
        new_valid = 1'b0;
    endtask

    task automatic frames(int n);
        for (int i = 0; i < n; i++) begin
            frame_done = 1'b1;
            @(negedge clk);
            frame_done = 1'b0;
            @(negedge clk);
        end
    endtask

    // driver: queue the expected word, then read the register out
    task automatic readout(logic [WORD_W-1:0] exp);
        exp_q.push_back(exp);
        cap = 1'b1;
        @(negedge clk);
        cap = 1'b0;
        sdi = 1'b1;
        for (int i = 0; i < WORD_W; i++) begin
            got_word[i] = sdo;
            shift = 1'b1;
            @(negedge clk);
            shift = 1'b0;
        end
        sdi = 1'b0;
        check("R3 sdi enters top bit", sdo, 1);
        -> word_done;
        upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
    endtask

    // monitor: compare each assembled word with the queued one
    always @(word_done) begin
        if (exp_q.size() == 0) check("R3 unexpected word", got_word, 32'hx);
        else check("R3 readout word", got_word, exp_q.pop_front());
    end

    initial begin
        for (int c = 0; c < 100000 && !finished; c++) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 valid", rpt_valid, 0);
        check("R1 overrun", rpt_overrun, 0);
        check("R1 pending", rpt_pending, 0);
        check("R1 sdo", sdo, 0);

        // R2, R3, R4: simple load and readout
        hold_frames = 3'd0;
        push(2'd1, 8'hA5, 6'd17);
        check("R2 valid", rpt_valid, 1);
        check("R2 no overrun", rpt_overrun, 0);
        readout(mk(1'b0, 2'd1, 8'hA5, 6'd17));
        check("R4 valid cleared", rpt_valid, 0);

        // R4: partial shift then update has no effect
        push(2'd2, 8'h3C, 6'd5);
        cap = 1'b1; @(negedge clk); cap = 1'b0;
        for (int i = 0; i < 5; i++) begin shift = 1'b1; @(negedge clk); shift = 1'b0; end
        upd = 1'b1; @(negedge clk); upd = 1'b0;
        check("R4 partial update keeps valid", rpt_valid, 1);
        readout(mk(1'b0, 2'd2, 8'h3C, 6'd5));
        check("R4 valid cleared after full read", rpt_valid, 0);

        // R5: immediate overwrite
        push(2'd1, 8'h01, 6'd1);
        push(2'd3, 8'hF0, 6'd62);
        check("R5 valid", rpt_valid, 1);
        check("R5 overrun", rpt_overrun, 1);
        readout(mk(1'b1, 2'd3, 8'hF0, 6'd62));
        check("R4 overrun cleared", rpt_overrun, 0);

        // R6: held for three frame periods
        hold_frames = 3'd3;
        push(2'd1, 8'h11, 6'd2);
        push(2'd2, 8'h22, 6'd3);
        check("R6 pending", rpt_pending, 1);
        check("R6 no overrun yet", rpt_overrun, 0);
        frames(2);
        check("R6 still pending after 2 frames", rpt_pending, 1);
        frames(1);
        check("R6 promoted after 3rd frame", rpt_pending, 0);
        check("R6 overrun set", rpt_overrun, 1);
        readout(mk(1'b1, 2'd2, 8'h22, 6'd3));

        // R7: readout promotes the pending report cleanly
        push(2'd1, 8'h33, 6'd4);
        push(2'd3, 8'h44, 6'd6);
        readout(mk(1'b0, 2'd1, 8'h33, 6'd4));
        check("R7 valid after promotion", rpt_valid, 1);
        check("R7 pending cleared", rpt_pending, 0);
        check("R7 no overrun", rpt_overrun, 0);
        readout(mk(1'b0, 2'd3, 8'h44, 6'd6));

        // R8: second arrival replaces the pending report
        push(2'd1, 8'h55, 6'd7);
        push(2'd2, 8'h66, 6'd8);
        push(2'd3, 8'h77, 6'd9);
        check("R8 overrun", rpt_overrun, 1);
        check("R8 pending", rpt_pending, 1);
        frames(3);
        check("R8 promoted", rpt_pending, 0);
        readout(mk(1'b1, 2'd3, 8'h77, 6'd9));

        // R9: reload between capture and update
        hold_frames = 3'd0;
        push(2'd1, 8'h88, 6'd10);
        cap = 1'b1; @(negedge clk); cap = 1'b0;
        push(2'd2, 8'h99, 6'd11);
        for (int i = 0; i < WORD_W; i++) begin shift = 1'b1; @(negedge clk); shift = 1'b0; end
        upd = 1'b1; @(negedge clk); upd = 1'b0;
        check("R9 new report kept", rpt_valid, 1);
        readout(mk(1'b1, 2'd2, 8'h99, 6'd11));
        check("R9 cleared after real read", rpt_valid, 0);

        @(negedge clk);
        check("R3 queue drained", exp_q.size(), 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule